// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store placed beside a direct-mapped cache. It keeps only lines that the main cache has thrown out. When the main cache misses, it presents the missing line address together with the line its refill would displace. The buffer compares that address with every stored entry at once.

On a match, the buffer returns the stored line one cycle later. In the same step it takes the displaced line into the entry it just freed, so the two lines trade places. With no match, the response tells the main cache to go to the next level. The displaced line is then stored in an empty entry if one exists, and otherwise in place of the least recently written entry.

Each entry keeps the whole line address as its tag, because an entry belongs to no particular set. The entry count is a parameter. It defaults to 4 and may be set anywhere from 1 to 8.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `rsp_hit` are 0, and the first lookup of any address misses.
- R2: A lookup accepted on a rising edge (`req_valid`=1) produces `rsp_valid`=1 on exactly the next cycle. `rsp_valid` is 0 in a cycle that follows no lookup.
- R3: When a valid entry holds exactly `req_addr`, the response has `rsp_hit`=1 and `rsp_data` equal to the line stored with that address.
- R4: The tag is the full `ADDR_W`-bit line address. Two addresses that share their low bits but differ in any upper bit occupy separate entries, and each returns its own line.
- R5: When no valid entry holds `req_addr`, the response has `rsp_hit`=0, which means the request goes to the next level.
- R6: On a hit with `ev_valid`=1, the matched line leaves the buffer (a later lookup of it misses). The displaced line `ev_addr`/`ev_data` is stored, and a later lookup of it hits with that data.
- R7: On a hit with `ev_valid`=0, the matched entry becomes invalid and nothing is written.
- R8: On a miss with `ev_valid`=1 while some entry is invalid, the displaced line goes into an invalid entry and every previously valid line stays retrievable.
- R9: On a miss with `ev_valid`=1 while all entries are valid, the entry written longest ago is dropped (its lookup then misses) and all other lines are kept.
- R10: A miss with `ev_valid`=0 changes no stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Main cache missed; a lookup is presented this cycle |
| req_addr | input | ADDR_W | Line address of the missing request |
| ev_valid | input | 1 | The refill displaces a valid main-cache line |
| ev_addr | input | ADDR_W | Full line address of the displaced line |
| ev_data | input | LINE_W | Data of the displaced line |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | 1: line found here; 0: fetch from next level |
| rsp_data | output | LINE_W | Line returned on a hit |

## Verification
Several properties are checked on every cycle. Responses arrive exactly one cycle after each lookup. At most one entry matches an address. The recency ranks always form a permutation. The occupancy count moves as each case requires: it stays the same on a swap, drops by one on a hit with no displaced line, and rises by one when a miss fills an empty entry.

Data correctness needs the bench's scenarios. These include which line a hit returns, a swapped-in line being retrievable, and the least recently written line being the one dropped. The bench runs a long pseudo-random sweep over a small address pool with colliding low bits and compares every response with an insertion-order model. Directed cases cover reset, full-tag separation and freeing an entry.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int VC_MAX_ENTRIES = 8;

  function automatic int vc_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 20,
  localparam int IDX_W  = vc_pkg::vc_idx_w(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              addr,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [ENTRIES-1:0] match_vec;

  // one comparator per entry, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (tags[g] == addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign hit = |match_vec;

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R4
endmodule

// File: rtl/vc_repl.sv
module vc_repl #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = vc_pkg::vc_idx_w(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic [IDX_W-1:0]   victim_idx
);
  // rank 0 = most recently written, ENTRIES-1 = oldest
  logic [ENTRIES-1:0][IDX_W-1:0] rank_q, rank_d;
  logic [ENTRIES-1:0]            rank_seen;
  logic [IDX_W-1:0]              free_idx, old_idx;
  logic                          any_free;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (rank_q[i] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
    end
    victim_idx = any_free ? free_idx : old_idx;
  end

  always_comb begin
    rank_d = rank_q;
    if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)           rank_d[i] = '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_d[i] = rank_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      rank_q <= rank_d;
    end
  end

  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < ENTRIES; i++) rank_seen[rank_q[i]] = 1'b1;
  end

  AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    &rank_seen); // R9
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 20,
  parameter int LINE_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [LINE_W-1:0] ev_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data
);
  localparam int IDX_W = vc_pkg::vc_idx_w(ENTRIES);

  logic [ENTRIES-1:0]             valid_q, valid_d, wr_en;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][LINE_W-1:0] data_q;
  logic                           hit;
  logic [IDX_W-1:0]               hit_idx, victim_idx, wr_idx;
  logic                           wr_any, clr_any;
  logic                           rsp_valid_q, rsp_hit_q;
  logic [LINE_W-1:0]              rsp_data_q;

  initial begin
    assert (ENTRIES >= 1 && ENTRIES <= vc_pkg::VC_MAX_ENTRIES);
  end

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid_q),
    .tags    (tag_q),
    .addr    (req_addr),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  vc_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (valid_q),
    .touch_en   (wr_any),
    .touch_idx  (wr_idx),
    .victim_idx (victim_idx)
  );

  // next state: swap into the hit slot, otherwise fill the chosen victim slot
  always_comb begin
    wr_any  = req_valid && ev_valid;
    clr_any = req_valid && hit && !ev_valid;
    wr_idx  = hit ? hit_idx : victim_idx;
    wr_en   = '0;
    valid_d = valid_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (IDX_W'(i) == wr_idx) begin
        if (wr_any) begin
          wr_en[i]   = 1'b1;
          valid_d[i] = 1'b1;
        end else if (clr_any) begin
          valid_d[i] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        tag_q[g]  <= ev_addr;
        data_q[g] <= ev_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_hit_q   <= req_valid && hit;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) rsp_data_q <= hit ? data_q[hit_idx] : '0;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_HIT_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R3
  AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && ev_valid) |=> ($countones(valid_q) == $countones($past(valid_q)))); // R6
  AST_HIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && !ev_valid) |=> ($countones(valid_q) + 1 == $countones($past(valid_q)))); // R7
  AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && ev_valid && !(&valid_q)) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1)); // R8
  AST_MISS_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && !ev_valid) |=> $stable(valid_q)); // R10
endmodule

// File: tb/sim_victim_buf.sv
module sim_victim_buf;
  localparam int N      = 4;
  localparam int ADDR_W = 20;
  localparam int LINE_W = 64;
  localparam int POOL   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              ev_valid = 1'b0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic [LINE_W-1:0] ev_data = '0;
  logic              rsp_valid, rsp_hit;
  logic [LINE_W-1:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model: addresses in write order, oldest at index 0
  logic [ADDR_W-1:0] mq [N];
  int                mn = 0;

  always #2.5 clk = ~clk;

  victim_buf #(.ENTRIES(N), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
  );

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {12'hA5C, a, 12'h3C5, ~a};
  endfunction

  function automatic logic [ADDR_W-1:0] pool_addr(input int i);
    return ADDR_W'(((i % 3) << 16) | (i / 3));
  endfunction

  function automatic int m_find(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < mn; i++) if (mq[i] == a) return i;
    return -1;
  endfunction

  task automatic m_remove(input int k);
    for (int i = k; i < mn - 1; i++) mq[i] = mq[i + 1];
    mn--;
  endtask

  task automatic check(input string tag, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one lookup; inputs set at a falling edge, response checked at the next one
  task automatic lookup(input logic [ADDR_W-1:0] a, input bit ev,
                        input logic [ADDR_W-1:0] ea, input string tag);
    int  k;
    bit  exp_hit;
    k = m_find(a);
    exp_hit = (k >= 0);
    req_valid = 1'b1; req_addr = a;
    ev_valid = ev; ev_addr = ea; ev_data = line_of(ea);
    if (exp_hit) m_remove(k);
    if (ev) begin
      if (mn == N) m_remove(0);
      mq[mn] = ea; mn++;
    end
    @(negedge clk);
    req_valid = 1'b0; ev_valid = 1'b0;
    check({tag, " valid"}, LINE_W'(rsp_valid), LINE_W'(1));
    check({tag, " hit"}, LINE_W'(rsp_hit), LINE_W'(exp_hit));
    if (exp_hit) check({tag, " data"}, rsp_data, line_of(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid at reset", LINE_W'(rsp_valid), '0);
    check("R1 rsp_hit at reset", LINE_W'(rsp_hit), '0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup(pool_addr(0), 1'b0, '0, "R1 first lookup");
    // R2 idle cycle gives no response
    @(negedge clk);
    check("R2 idle", LINE_W'(rsp_valid), '0);
    // R10 miss with nothing displaced writes nothing
    lookup(pool_addr(1), 1'b0, '0, "R10");
    lookup(pool_addr(1), 1'b0, '0, "R10 recheck");
    // R4 same low bits, different upper bits
    lookup(pool_addr(2), 1'b1, 20'h00005, "R5");
    lookup(pool_addr(3), 1'b1, 20'h10005, "R8");
    lookup(20'h20005, 1'b0, '0, "R4 absent alias");
    lookup(20'h10005, 1'b0, '0, "R4 upper");
    lookup(20'h00005, 1'b0, '0, "R4 lower");
    // R7 freed entry misses afterwards
    lookup(20'h00005, 1'b0, '0, "R7");
    // R9 fill to capacity then overflow
    for (int i = 0; i < N + 1; i++) lookup(pool_addr(4), 1'b1, pool_addr(i + 5), "R9 fill");
    lookup(pool_addr(5), 1'b0, '0, "R9 oldest dropped");
    lookup(pool_addr(6), 1'b1, pool_addr(11), "R6 swap");
    lookup(pool_addr(11), 1'b0, '0, "R6 swapped in");
    // pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      int ra, ec;
      bit ev;
      logic [ADDR_W-1:0] a, e;
      string tag;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = int'(lfsr[7:0]) % POOL;
      a  = pool_addr(ra);
      ev = (lfsr[9:8] != 2'b00);
      ec = int'(lfsr[15:10]) % POOL;
      e  = pool_addr(ec);
      while (m_find(e) >= 0 || e == a) begin
        ec = (ec + 1) % POOL;
        e  = pool_addr(ec);
      end
      if (m_find(a) >= 0) tag = ev ? "R6" : "R3";
      else if (!ev)       tag = "R10";
      else                tag = (mn == N) ? "R9" : "R8";
      lookup(a, ev, e, tag);
      if (lfsr[0] && lfsr[3]) begin
        @(negedge clk);
        check("R2 gap", LINE_W'(rsp_valid), '0);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule